// File: doc/BRIEF.md
# Programmable PWM Timer Channel

This block generates one pulse-width-modulated output from a counter that a clock prescaler advances. Software programs it through four word registers: a live counter, a period, a duty value and a control word. Each period starts with the counter at zero. The counter climbs by one per prescaled tick and returns to zero after reaching period minus one. The output is driven to its active level while the counter lies inside the duty window, and to the opposite level for the rest of the period.

A build-time parameter chooses between two register arrangements. In arrangement A the counter advances once every two clocks, and the output runs only when both of two control bits are set. In arrangement B the counter advances on every clock. Arrangement B also adds a single-period mode, a choice of active level, a separate idle level and a right-aligned window. Software can write the counter directly, either to restart a period or to jump to another phase.

Top module: `pwm_chan_top`

## Requirements
- R1: Registers are selected by word index `bus_sel` (byte offset divided by 4). Index 0 is the counter and index 3 is control. In arrangement A (LAYOUT=0) index 1 is duty and index 2 is period. In arrangement B (LAYOUT=1) index 1 is period and index 2 is duty. Each register reads back on `bus_rdata` in the same cycle, and all registers read 0 after reset.
- R2: While counting, the counter rises by one every 2 clocks in arrangement A and every clock in arrangement B. The first increment comes 2 clocks (A) or 1 clock (B) after enabling.
- R3: In arrangement A the channel runs only when control bits 0 and 3 are both 1. In arrangement B it runs when control bit 0 is 1.
- R4: While the channel does not run, the counter reads 0, writes to the counter are ignored and the output sits at the idle level.
- R5: In left-aligned mode the duty phase covers counter values below duty. The counter returns to 0 on the tick after it reaches period minus 1, and a period of 0 or 1 keeps it at 0.
- R6: A duty of 0 never shows the duty phase. A duty of at least the period shows the duty phase for the whole period.
- R7: In arrangement B, control bit 3 gives the duty-phase level (1 = high) and the rest of the period takes the opposite level. Control bit 4 gives the idle level. In arrangement A the duty phase is high and the idle level is low.
- R8: In arrangement B, control bit 5 set selects right alignment: the duty phase covers counter values of at least period minus duty, and never occurs when duty is 0.
- R9: In arrangement B with control bit 1 clear, the channel completes one period, then holds the counter at 0 with the output idle. A write to the counter or control register starts it again. Arrangement A always repeats.
- R10: A counter write while running loads the written value and restarts the prescaler. A loaded value at or above period-1 returns to 0 at the next tick.
- R11: Control bits without a function read back as written and change nothing. In arrangement A these are all bits except 0 and 3, and in arrangement B all bits except 0, 1, 3, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_sel | input | 2 | Register word index |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the selected register |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest states to reach are the edges of the duty window: duty of 0, duty equal to the period, duty beyond the period, and the degenerate periods 0 and 1. Each of these must be checked in both alignments and both polarities. The bench sweeps every duty from 0 to period+1 over several small periods and predicts the level of every cycle arithmetically. A second hard situation is a counter value at or above the period, which normal counting never produces. The bench forces it through a direct counter write, and it also stops a single-period run and then restarts it.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam logic [1:0] SEL_COUNT = 2'd0;
  localparam logic [1:0] SEL_CTRL  = 2'd3;

  localparam int LAYOUT_A = 0;
  localparam int LAYOUT_B = 1;

  // word index of the period register for a layout
  function automatic logic [1:0] period_sel(input int layout);
    return (layout == LAYOUT_A) ? 2'd2 : 2'd1;
  endfunction

  // word index of the duty register for a layout
  function automatic logic [1:0] duty_sel(input int layout);
    return (layout == LAYOUT_A) ? 2'd1 : 2'd2;
  endfunction

  // clocks per counter tick for a layout
  function automatic int prescale_for(input int layout);
    return (layout == LAYOUT_A) ? 2 : 1;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  input  logic restart,
  output logic tick
);
  localparam int PW = (PRE > 1) ? $clog2(PRE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRE - 1);

  logic [PW-1:0] div_q;

  assign tick = count_en && !restart && (div_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                  div_q <= '0;
    else if (restart || !count_en) div_q <= '0;
    else if (div_q == LAST)      div_q <= '0;
    else                         div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] period,
  input  logic          one_shot,
  input  logic          rearm,
  output logic [DW-1:0] cnt,
  output logic          done,
  output logic          wrap
);
  logic [DW:0] nxt;

  assign nxt  = {1'b0, cnt} + (DW+1)'(1);
  assign wrap = tick && (nxt >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (load) begin
      cnt  <= load_val;
      done <= 1'b0;
    end else begin
      if (rearm) done <= 1'b0;
      if (tick)  cnt  <= wrap ? '0 : nxt[DW-1:0];
      if (wrap && one_shot) done <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_shaper.sv
module pwm_shaper #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] period,
  input  logic [DW-1:0] duty,
  input  logic          right_al,
  input  logic          act_lvl,
  input  logic          idle_lvl,
  input  logic          idle,
  output logic          level
);
  // true while the counter lies inside the duty window
  function automatic logic in_window(input logic [DW-1:0] c, input logic [DW-1:0] p,
                                     input logic [DW-1:0] d, input logic right);
    logic [DW:0] sum;
    sum = {1'b0, c} + {1'b0, d};
    if (right) return (d != '0) && (sum >= {1'b0, p});
    return c < d;
  endfunction

  logic phase;
  assign phase = in_window(cnt, period, duty, right_al);
  assign level = idle ? idle_lvl : (phase ? act_lvl : !act_lvl);
endmodule

// File: rtl/pwm_chan_top.sv
module pwm_chan_top #(
  parameter int LAYOUT = 1,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_sel,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          pwm_out
);
  import pwm_chan_pkg::*;

  localparam logic [1:0] SEL_PER  = period_sel(LAYOUT);
  localparam logic [1:0] SEL_DUTY = duty_sel(LAYOUT);
  localparam int         PRE      = prescale_for(LAYOUT);

  logic [DW-1:0] period_q, duty_q, ctrl_q, cnt;
  logic wr_cnt, wr_per, wr_duty, wr_ctrl;
  logic run, cont, act_lvl, idle_lvl, right_al;
  logic tick, wrap, done, count_en, idle;

  assign wr_cnt  = bus_wr && (bus_sel == SEL_COUNT);
  assign wr_per  = bus_wr && (bus_sel == SEL_PER);
  assign wr_duty = bus_wr && (bus_sel == SEL_DUTY);
  assign wr_ctrl = bus_wr && (bus_sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      duty_q   <= '0;
      ctrl_q   <= '0;
    end else begin
      if (wr_per)  period_q <= bus_wdata;
      if (wr_duty) duty_q   <= bus_wdata;
      if (wr_ctrl) ctrl_q   <= bus_wdata;
    end
  end

  generate
    if (LAYOUT == LAYOUT_A) begin : g_layout_a
      assign run      = ctrl_q[0] && ctrl_q[3];
      assign cont     = 1'b1;
      assign act_lvl  = 1'b1;
      assign idle_lvl = 1'b0;
      assign right_al = 1'b0;
    end else begin : g_layout_b
      assign run      = ctrl_q[0];
      assign cont     = ctrl_q[1];
      assign act_lvl  = ctrl_q[3];
      assign idle_lvl = ctrl_q[4];
      assign right_al = ctrl_q[5];
    end
  endgenerate

  assign count_en = run && !done;
  assign idle     = !run || done;

  pwm_prescaler #(.PRE(PRE)) u_pre (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .restart(wr_cnt), .tick(tick)
  );

  pwm_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .load(wr_cnt),
    .load_val(bus_wdata), .period(period_q), .one_shot(!cont), .rearm(wr_ctrl),
    .cnt(cnt), .done(done), .wrap(wrap)
  );

  pwm_shaper #(.DW(DW)) u_shape (
    .cnt(cnt), .period(period_q), .duty(duty_q), .right_al(right_al),
    .act_lvl(act_lvl), .idle_lvl(idle_lvl), .idle(idle), .level(pwm_out)
  );

  always_comb begin
    unique case (bus_sel)
      SEL_COUNT: bus_rdata = cnt;
      SEL_PER:   bus_rdata = period_q;
      SEL_DUTY:  bus_rdata = duty_q;
      default:   bus_rdata = ctrl_q;
    endcase
  end
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int DW  = 32,
  parameter int PRE = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          done,
  input logic          tick,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] period,
  input logic [DW-1:0] duty,
  input logic          wr_cnt,
  input logic          wr_ctrl,
  input logic [DW-1:0] wdata,
  input logic          pwm_out,
  input logic          act_lvl,
  input logic          idle_lvl
);
  logic [DW:0] nxt;
  assign nxt = {1'b0, cnt} + (DW+1)'(1);

  a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

  a_r4_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> pwm_out == idle_lvl);

  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (PRE > 1 && tick) |=> !tick);

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && !wr_ctrl && nxt >= {1'b0, period}) |=> cnt == '0);

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && !wr_ctrl && nxt < {1'b0, period}) |=> cnt == $past(nxt[DW-1:0]));

  a_r6_duty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done && duty == '0) |-> pwm_out == !act_lvl);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pwm_out == idle_lvl);

  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_cnt) |=> cnt == $past(wdata));
endmodule

bind pwm_chan_top pwm_chan_chk #(.DW(DW), .PRE(PRE)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .done(done), .tick(tick), .cnt(cnt),
  .period(period_q), .duty(duty_q), .wr_cnt(wr_cnt), .wr_ctrl(wr_ctrl),
  .wdata(bus_wdata), .pwm_out(pwm_out), .act_lvl(act_lvl), .idle_lvl(idle_lvl)
);

// File: tb/pwm_chan_top_tb_top.sv
module pwm_chan_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_b = 1'b0, wr_a = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_b, rdata_a;
  logic out_b, out_a;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pwm_chan_top #(.LAYOUT(1), .DW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_b), .bus_sel(sel),
    .bus_wdata(wdata), .bus_rdata(rdata_b), .pwm_out(out_b)
  );

  pwm_chan_top #(.LAYOUT(0), .DW(32)) dut_a (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_a), .bus_sel(sel),
    .bus_wdata(wdata), .bus_rdata(rdata_a), .pwm_out(out_a)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // write takes effect at the edge between two falling edges
  task automatic wr(input bit to_a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    sel = s; wdata = d;
    if (to_a) wr_a = 1'b1; else wr_b = 1'b1;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic rd(input bit from_a, input logic [1:0] s, output logic [31:0] v);
    sel = s;
    #1;
    v = from_a ? rdata_a : rdata_b;
  endtask

  function automatic logic exp_phase(input int c, input int p, input int d, input bit right);
    if (right) return (d != 0) && (c + d >= p);
    return c < d;
  endfunction

  initial begin
    #4000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    for (int s = 0; s < 4; s++) begin
      rd(0, 2'(s), v); chk("R1 reset B", v, 0);
      rd(1, 2'(s), v); chk("R1 reset A", v, 0);
    end
    chk("R4 idle out B after reset", 32'(out_b), 0);
    chk("R4 idle out A after reset", 32'(out_a), 0);

    // R1: index mapping
    wr(0, 2'd1, 32'h11); wr(0, 2'd2, 32'h22);
    rd(0, 2'd1, v); chk("R1 B index1 period", v, 32'h11);
    rd(0, 2'd2, v); chk("R1 B index2 duty", v, 32'h22);
    wr(1, 2'd1, 32'd3); wr(1, 2'd2, 32'd6);
    rd(1, 2'd1, v); chk("R1 A index1 duty", v, 3);
    rd(1, 2'd2, v); chk("R1 A index2 period", v, 6);

    // R3: arrangement A needs both bits
    wr(1, 2'd3, 32'h1);
    repeat (5) @(negedge clk);
    rd(1, 2'd0, v); chk("R3 A bit0 only counter", v, 0);
    chk("R3 A bit0 only out", 32'(out_a), 0);
    wr(1, 2'd3, 32'h8);
    repeat (5) @(negedge clk);
    rd(1, 2'd0, v); chk("R3 A bit3 only counter", v, 0);
    // R4: counter write ignored while stopped
    wr(1, 2'd0, 32'd4);
    rd(1, 2'd0, v); chk("R4 A write ignored", v, 0);

    // R2 R5 R11: run A with extra undefined bits (incl. bits 4,5)
    wr(1, 2'd3, 32'hFFFF_FF39);
    rd(1, 2'd3, v); chk("R11 A ctrl readback", v, 32'hFFFF_FF39);
    for (int k = 0; k < 24; k++) begin
      int c;
      c = (k / 2) % 6;
      rd(1, 2'd0, v); chk("R2 A counter", v, 32'(c));
      chk("R5 A out", 32'(out_a), 32'(c < 3));
      @(negedge clk);
    end
    // R10: counter write restarts prescaler in A
    wr(1, 2'd0, 32'd2);
    rd(1, 2'd0, v); chk("R10 A loaded", v, 2);
    @(negedge clk);
    rd(1, 2'd0, v); chk("R10 A prescaler restarted", v, 2);
    @(negedge clk);
    rd(1, 2'd0, v); chk("R10 A next tick", v, 3);

    // R5 R6 R7 R8: sweep in arrangement B
    for (int al = 0; al < 2; al++) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int pi = 0; pi < 5; pi++) begin
          int p, idl;
          p = (pi == 4) ? 5 : pi;
          idl = al ^ pol;
          for (int d = 0; d <= p + 1; d++) begin
            wr(0, 2'd3, 32'(idl << 4));
            chk("R7 idle level", 32'(out_b), 32'(idl));
            wr(0, 2'd1, 32'(p));
            wr(0, 2'd2, 32'(d));
            wr(0, 2'd3, 32'(1 | 2 | (pol << 3) | (idl << 4) | (al << 5)));
            for (int k = 0; k < 2 * p + 3; k++) begin
              int c;
              logic ph;
              c = (p <= 1) ? 0 : (k % p);
              ph = exp_phase(c, p, d, al[0]);
              rd(0, 2'd0, v); chk("R5 B counter", v, 32'(c));
              if (al != 0) chk("R8 right aligned out", 32'(out_b), 32'(ph ? pol[0] : !pol[0]));
              else if (d == 0 || d >= p) chk("R6 duty edge out", 32'(out_b), 32'(ph ? pol[0] : !pol[0]));
              else chk("R7 left aligned out", 32'(out_b), 32'(ph ? pol[0] : !pol[0]));
              @(negedge clk);
            end
          end
        end
      end
    end

    // R9: single period in B
    wr(0, 2'd3, 32'h0);
    wr(0, 2'd1, 32'd4);
    wr(0, 2'd2, 32'd2);
    wr(0, 2'd3, 32'h9);
    for (int k = 0; k < 4; k++) begin
      rd(0, 2'd0, v); chk("R9 first period counter", v, 32'(k));
      chk("R9 first period out", 32'(out_b), 32'(k < 2));
      @(negedge clk);
    end
    for (int k = 0; k < 3; k++) begin
      rd(0, 2'd0, v); chk("R9 stopped counter", v, 0);
      chk("R9 stopped out idle", 32'(out_b), 0);
      @(negedge clk);
    end
    wr(0, 2'd0, 32'd0);
    chk("R9 restart by counter write", 32'(out_b), 1);
    @(negedge clk);
    rd(0, 2'd0, v); chk("R9 counting again", v, 1);

    // R10: counter writes in B
    wr(0, 2'd3, 32'h0);
    wr(0, 2'd1, 32'd8);
    wr(0, 2'd2, 32'd4);
    wr(0, 2'd3, 32'hB);
    repeat (5) @(negedge clk);
    wr(0, 2'd0, 32'd0);
    rd(0, 2'd0, v); chk("R10 B restart", v, 0);
    chk("R10 B restart out", 32'(out_b), 1);
    wr(0, 2'd0, 32'd20);
    rd(0, 2'd0, v); chk("R10 B load beyond period", v, 20);
    chk("R10 B beyond period out", 32'(out_b), 0);
    @(negedge clk);
    rd(0, 2'd0, v); chk("R10 B wrap after beyond", v, 0);

    // R11: undefined bits in B
    wr(0, 2'd3, 32'hFFFF_FFC4);
    rd(0, 2'd3, v); chk("R11 B ctrl readback", v, 32'hFFFF_FFC4);
    repeat (3) @(negedge clk);
    rd(0, 2'd0, v); chk("R11 B undefined bits do not run", v, 0);
    chk("R11 B out idle", 32'(out_b), 0);
    // R4: counter write ignored while disabled in B
    wr(0, 2'd0, 32'd7);
    rd(0, 2'd0, v); chk("R4 B write ignored", v, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule